// File: doc/BRIEF.md
# Three-Phase Hysteresis Current Controller

This block closes the current loop of a three-leg voltage-source inverter. Each leg has a measured phase current and a reference current, both given as 12-bit offset-binary samples. On one shared sample strobe, all phases compute the signed error at once. Each phase then passes its error through its own hysteresis comparator. The comparator decides whether the upper or the lower switch of that leg should conduct.

The width of the hysteresis band follows the reference amplitude. The band is the amplitude multiplied by a programmable fraction, and a fraction field of zero selects a default of about five percent. Each change of command passes through a dead-time sequencer. The sequencer holds both switches of the leg off for a programmable number of cycles before it turns the new switch on. A per-phase counter records every change of switching state, so that the switching rate can be monitored. A disable input and reset both force every gate off.

Top module: `hcc_ctrl`

## Requirements
- R1: Measured and reference samples are offset binary, with 2048 meaning zero current. The phase error is reference minus measured, taken as a signed value over the full range: measured 0 with reference 4095 gives +4095, and the reverse gives -4095.
- R2: The half band is floor(floor(i_amp * k / 256) / 2). Here k is i_band, or 13 (about 5 percent) when i_band is 0.
- R3: On a sample strobe, an error greater than the half band commands the upper switch (o_hi bit high, o_lo bit low once the dead time has passed).
- R4: On a sample strobe, an error below minus the half band commands the lower switch (o_lo bit high, o_hi bit low once the dead time has passed).
- R5: An error within plus or minus the half band, inclusive, keeps the previous command. After reset the command is both-off, and an in-band error keeps both gates off.
- R6: Commands and counters change only on a cycle where i_smp is high, and every phase is decided on that same strobe. Input changes without a strobe have no effect.
- R7: After any change of a phase's command, both gates of that leg stay low for exactly i_dead + 1 clock cycles before the newly commanded gate rises. The two gates of a leg are never high together.
- R8: Each phase's counter in o_swcnt (phase p at bits p*16 upward) rises by exactly one in the cycle its command changes, and otherwise holds its value.
- R9: While i_en is low, all gates are low from the next clock edge and every command returns to both-off without counting. Strobes are ignored until i_en is high again.
- R10: After reset, all six gates are low and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_en | input | 1 | Enable; low forces all gates off |
| i_smp | input | 1 | Sample strobe for all phases |
| i_meas | input | NPH*SW | Measured currents, phase p at bits p*SW upward |
| i_ref | input | NPH*SW | Reference currents, same packing |
| i_amp | input | SW-1 | Reference amplitude magnitude |
| i_band | input | FW | Band fraction in 1/2^FW units, 0 selects default |
| i_dead | input | DW | Dead-time count |
| o_hi | output | NPH | Upper switch gates |
| o_lo | output | NPH | Lower switch gates |
| o_swcnt | output | NPH*CW | Per-phase switching counters |

## Verification
The bench builds the block with its defaults: three phases, 12-bit samples, an 8-bit band fraction, an 8-bit dead-time field, 16-bit counters and registered gate outputs. With these settings the half band ranges from zero up to 1019 codes. That small range lets the bench sweep the error through every value across both band edges, rising and then falling, for five amplitude and fraction pairs, one of them the default fraction. A dead-time setting of 2 keeps each sweep step short. Separate directed runs at dead-time settings of 0 and 5 measure the off window one cycle at a time, and drive full-scale samples to reach the extremes of the signed error.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

   // Switching command of one inverter leg
   typedef enum logic [1:0] {
      LEG_OFF = 2'b00,
      LEG_HI  = 2'b01,
      LEG_LO  = 2'b10
   } leg_cmd_t;

endpackage

// File: rtl/hcc_band.sv
// Scales the reference amplitude by the band fraction and halves it.
module hcc_band #(
   parameter int SW        = 12,
   parameter int FW        = 8,
   parameter int BAND_DFLT = 13,
   localparam int AW = SW - 1,
   localparam int PW = AW + FW,
   localparam int HW = SW - 2
) (
   input  logic [AW-1:0] amp,
   input  logic [FW-1:0] frac,
   output logic [HW-1:0] half
);

   logic [FW-1:0] frac_eff;
   logic [PW-1:0] prod;

   // a zero fraction field selects the built-in default band
   assign frac_eff = (frac == '0) ? FW'(BAND_DFLT) : frac;
   assign prod     = PW'(amp) * PW'(frac_eff);
   // drop the fraction bits and one more bit for the halving
   assign half     = prod[PW-1:FW+1];

endmodule

// File: rtl/hcc_phase_dec.sv
// Hysteresis decision and switching counter for one phase.
module hcc_phase_dec
   import hcc_pkg::*;
#(
   parameter int SW = 12,
   parameter int CW = 16,
   localparam int EW = SW + 1,
   localparam int HW = SW - 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          smp,
   input  logic [SW-1:0] meas,
   input  logic [SW-1:0] setp,
   input  logic [HW-1:0] half,
   output leg_cmd_t      cmd,
   output logic [CW-1:0] cnt
);

   logic signed [EW-1:0] meas_s;
   logic signed [EW-1:0] setp_s;
   logic signed [EW-1:0] err;
   logic signed [EW-1:0] lim;
   leg_cmd_t             nxt;

   // offset binary to two's complement: invert the top bit, then sign-extend
   assign meas_s = {{2{~meas[SW-1]}}, meas[SW-2:0]};
   assign setp_s = {{2{~setp[SW-1]}}, setp[SW-2:0]};
   assign err    = setp_s - meas_s;
   assign lim    = $signed({3'b000, half});

   always_comb begin
      nxt = cmd;
      if (err > lim) begin
         nxt = LEG_HI;
      end else if (err < -lim) begin
         nxt = LEG_LO;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd <= LEG_OFF;
         cnt <= '0;
      end else if (!en) begin
         cmd <= LEG_OFF;
      end else if (smp) begin
         cmd <= nxt;
         if (nxt != cmd) begin
            cnt <= cnt + CW'(1);
         end
      end
   end

endmodule

// File: rtl/hcc_leg_dt.sv
// Dead-time sequencer and gate driver for one inverter leg.
module hcc_leg_dt
   import hcc_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit GATE_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  leg_cmd_t      cmd,
   input  logic [DW-1:0] dead,
   output logic          hi,
   output logic          lo
);

   leg_cmd_t      tgt;
   logic [DW-1:0] wait_cnt;
   logic          armed;
   logic          hi_c;
   logic          lo_c;

   // A command change disarms the leg and loads the dead count.
   // The leg re-arms one cycle after the count reaches zero, so that
   // there are always dead+1 cycles with both switches off.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt      <= LEG_OFF;
         wait_cnt <= '0;
         armed    <= 1'b0;
      end else if (!en) begin
         tgt      <= LEG_OFF;
         wait_cnt <= '0;
         armed    <= 1'b0;
      end else if (cmd != tgt) begin
         tgt      <= cmd;
         wait_cnt <= dead;
         armed    <= 1'b0;
      end else if (!armed) begin
         if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - DW'(1);
         end else begin
            armed <= 1'b1;
         end
      end
   end

   assign hi_c = armed && (tgt == LEG_HI);
   assign lo_c = armed && (tgt == LEG_LO);

   generate
      if (GATE_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi <= 1'b0;
               lo <= 1'b0;
            end else begin
               hi <= hi_c && en;
               lo <= lo_c && en;
            end
         end
      end else begin : g_comb
         assign hi = hi_c;
         assign lo = lo_c;
      end
   endgenerate

endmodule

// File: rtl/hcc_ctrl.sv
// Three-phase (NPH-phase) hysteresis current controller top.
module hcc_ctrl
   import hcc_pkg::*;
#(
   parameter int NPH       = 3,
   parameter int SW        = 12,
   parameter int FW        = 8,
   parameter int DW        = 8,
   parameter int CW        = 16,
   parameter int BAND_DFLT = 13,
   parameter bit GATE_REG  = 1'b1,
   localparam int AW = SW - 1,
   localparam int HW = SW - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_en,
   input  logic              i_smp,
   input  logic [NPH*SW-1:0] i_meas,
   input  logic [NPH*SW-1:0] i_ref,
   input  logic [AW-1:0]     i_amp,
   input  logic [FW-1:0]     i_band,
   input  logic [DW-1:0]     i_dead,
   output logic [NPH-1:0]    o_hi,
   output logic [NPH-1:0]    o_lo,
   output logic [NPH*CW-1:0] o_swcnt
);

   // elaboration-time parameter checks
   if (NPH < 1) begin : g_bad_nph
      $error("hcc_ctrl: NPH must be at least 1");
   end
   if (SW < 4) begin : g_bad_sw
      $error("hcc_ctrl: SW must be at least 4");
   end
   if (FW < 1) begin : g_bad_fw
      $error("hcc_ctrl: FW must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("hcc_ctrl: DW must be at least 1");
   end
   if (CW < 2) begin : g_bad_cw
      $error("hcc_ctrl: CW must be at least 2");
   end
   if (BAND_DFLT < 1 || BAND_DFLT >= (1 << FW)) begin : g_bad_dflt
      $error("hcc_ctrl: BAND_DFLT must fit in FW bits and be nonzero");
   end

   logic [HW-1:0] half;

   hcc_band #(
      .SW        (SW),
      .FW        (FW),
      .BAND_DFLT (BAND_DFLT)
   ) u_band (
      .amp  (i_amp),
      .frac (i_band),
      .half (half)
   );

   generate
      for (genvar p = 0; p < NPH; p++) begin : g_ph
         leg_cmd_t cmd;

         hcc_phase_dec #(
            .SW (SW),
            .CW (CW)
         ) u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (i_en),
            .smp   (i_smp),
            .meas  (i_meas[p*SW +: SW]),
            .setp  (i_ref[p*SW +: SW]),
            .half  (half),
            .cmd   (cmd),
            .cnt   (o_swcnt[p*CW +: CW])
         );

         hcc_leg_dt #(
            .DW       (DW),
            .GATE_REG (GATE_REG)
         ) u_dt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (i_en),
            .cmd   (cmd),
            .dead  (i_dead),
            .hi    (o_hi[p]),
            .lo    (o_lo[p])
         );
      end
   endgenerate

endmodule

// File: rtl/hcc_ctrl_chk.sv
// Property checker for hcc_ctrl, attached through bind.
module hcc_ctrl_chk #(
   parameter int NPH = 3,
   parameter int CW  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              i_en,
   input logic              i_smp,
   input logic [NPH-1:0]    o_hi,
   input logic [NPH-1:0]    o_lo,
   input logic [NPH*CW-1:0] o_swcnt
);

   for (genvar p = 0; p < NPH; p++) begin : g_p
      // R7
      no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(o_hi[p] && o_lo[p]));

      // R7
      hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(o_hi[p]) |-> !$past(o_lo[p]));

      // R7
      lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(o_lo[p]) |-> !$past(o_hi[p]));

      // R9
      dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(i_en) |-> (!o_hi[p] && !o_lo[p]));

      // R6
      cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(i_smp) |-> $stable(o_swcnt[p*CW +: CW]));

      // R8
      cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (o_swcnt[p*CW +: CW] == $past(o_swcnt[p*CW +: CW])) ||
         (o_swcnt[p*CW +: CW] == $past(o_swcnt[p*CW +: CW]) + CW'(1)));
   end

endmodule

bind hcc_ctrl hcc_ctrl_chk #(
   .NPH (NPH),
   .CW  (CW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .i_en    (i_en),
   .i_smp   (i_smp),
   .o_hi    (o_hi),
   .o_lo    (o_lo),
   .o_swcnt (o_swcnt)
);

// File: tb/tb_hcc_ctrl.sv
module tb_hcc_ctrl;

   localparam int NPH = 3;
   localparam int SW  = 12;
   localparam int FW  = 8;
   localparam int DW  = 8;
   localparam int CW  = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              en;
   logic              smp;
   logic [NPH*SW-1:0] meas;
   logic [NPH*SW-1:0] rf;
   logic [SW-2:0]     amp;
   logic [FW-1:0]     band;
   logic [DW-1:0]     dead;
   logic [NPH-1:0]    hi;
   logic [NPH-1:0]    lo;
   logic [NPH*CW-1:0] swc;

   always #4 clk = ~clk;

   hcc_ctrl dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .i_en    (en),
      .i_smp   (smp),
      .i_meas  (meas),
      .i_ref   (rf),
      .i_amp   (amp),
      .i_band  (band),
      .i_dead  (dead),
      .o_hi    (hi),
      .o_lo    (lo),
      .o_swcnt (swc)
   );

   int checks = 0;
   int errors = 0;
   int st[NPH];     // 0 off, 1 upper, 2 lower
   int cnt_m[NPH];
   int half_m;
   int mv[NPH];
   int rv[NPH];

   task automatic chk(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int half_of(int a, int f);
      int k = (f == 0) ? 13 : f;
      return ((a * k) >> 8) >> 1;
   endfunction

   task automatic set_band(int a, int f);
      @(negedge clk);
      amp    = (SW-1)'(a);
      band   = FW'(f);
      half_m = half_of(a, f);
   endtask

   // drive mv/rv, pulse the strobe for one cycle, update the model
   task automatic fire();
      @(negedge clk);
      for (int p = 0; p < NPH; p++) begin
         meas[p*SW +: SW] = SW'(mv[p]);
         rf[p*SW +: SW]   = SW'(rv[p]);
      end
      smp = 1'b1;
      @(negedge clk);
      smp = 1'b0;
      if (en) begin
         for (int p = 0; p < NPH; p++) begin
            int e = rv[p] - mv[p];
            int n = st[p];
            if (e > half_m) n = 1;
            else if (e < -half_m) n = 2;
            if (n != st[p]) cnt_m[p]++;
            st[p] = n;
         end
      end
   endtask

   task automatic fire_err(int e0, int e1, int e2);
      int e[NPH];
      e = '{e0, e1, e2};
      for (int p = 0; p < NPH; p++) begin
         mv[p] = 1748 + p * 100;
         rv[p] = mv[p] + e[p];
      end
      fire();
   endtask

   task automatic settle();
      repeat (int'(dead) + 6) @(negedge clk);
   endtask

   task automatic check_all(string req);
      for (int p = 0; p < NPH; p++) begin
         chk(req, int'(hi[p]), (st[p] == 1) ? 1 : 0, $sformatf("ph%0d upper gate", p));
         chk(req, int'(lo[p]), (st[p] == 2) ? 1 : 0, $sformatf("ph%0d lower gate", p));
         chk(req, int'(swc[p*CW +: CW]), cnt_m[p] & 16'hFFFF, $sformatf("ph%0d count", p));
      end
   endtask

   task automatic sweep(int a, int f);
      set_band(a, f);
      for (int e = -half_m - 3; e <= half_m + 3; e++) begin
         fire_err(e, e - 1, e + 1);
         settle();
         check_all("R2 R3 R4 R5 sweep up");
      end
      for (int e = half_m + 3; e >= -half_m - 3; e--) begin
         fire_err(e, e + 1, e - 1);
         settle();
         check_all("R2 R3 R4 R5 sweep down");
      end
   endtask

   // count cycles with both phase-0 gates low until the upper gate rises
   task automatic measure_gap(int d);
      int off = 0;
      dead = DW'(d);
      fire_err(-400, 0, 0);
      settle();
      fire_err(400, 0, 0);
      for (int i = 0; i < 100; i++) begin
         if (hi[0]) break;
         if (!lo[0]) off++;
         @(negedge clk);
      end
      chk("R7", off, d + 1, $sformatf("off cycles at dead=%0d", d));
      chk("R7", int'(hi[0]), 1, "upper gate after dead time");
      settle();
      check_all("R7");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      en    = 1'b0;
      smp   = 1'b0;
      meas  = '0;
      rf    = '0;
      amp   = '0;
      band  = '0;
      dead  = DW'(2);
      half_m = 0;
      for (int p = 0; p < NPH; p++) begin
         st[p] = 0;
         cnt_m[p] = 0;
         mv[p] = 2048;
         rv[p] = 2048;
      end
      repeat (3) @(negedge clk);
      // R10 reset state
      check_all("R10");
      rst_n = 1'b1;
      @(negedge clk);
      en = 1'b1;
      set_band(2047, 13);

      // R5 in-band after reset keeps both off
      fire_err(0, 20, -20);
      settle();
      check_all("R5 in band from reset");

      // R6 no strobe: large errors have no effect
      @(negedge clk);
      for (int p = 0; p < NPH; p++) begin
         meas[p*SW +: SW] = SW'(1000);
         rf[p*SW +: SW]   = SW'(3000);
      end
      settle();
      check_all("R6 no strobe");

      // R6 all phases decided on the same strobe
      fire_err(300, -300, 300);
      for (int p = 0; p < NPH; p++)
         chk("R6", int'(swc[p*CW +: CW]), cnt_m[p] & 16'hFFFF, $sformatf("ph%0d same-strobe count", p));
      settle();
      check_all("R6");

      // R1 full-scale extremes
      mv = '{0, 4095, 2048};
      rv = '{4095, 0, 2048};
      fire();
      settle();
      check_all("R1 extremes");
      mv = '{4095, 0, 2047};
      rv = '{0, 4095, 2049};
      fire();
      settle();
      check_all("R1 extremes reversed");

      // R7 dead-time window
      measure_gap(5);
      measure_gap(0);
      dead = DW'(2);

      // R9 disable
      @(negedge clk);
      en = 1'b0;
      for (int p = 0; p < NPH; p++) st[p] = 0;
      repeat (2) @(negedge clk);
      check_all("R9 disabled");
      fire_err(900, -900, 900);
      settle();
      check_all("R9 strobe while disabled");
      @(negedge clk);
      en = 1'b1;
      fire_err(10, -10, 0);
      settle();
      check_all("R9 re-enabled in band");
      fire_err(-200, 200, -200);
      settle();
      check_all("R9 R8 re-enabled switch");

      // R2 R3 R4 R5 R8 sweeps across the band edges
      sweep(2047, 13);
      sweep(2047, 0);
      sweep(1000, 64);
      sweep(0, 200);
      sweep(2047, 255);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule